// File: doc/BRIEF.md
# TCE IOMMU address translator

This block maps device DMA addresses onto system physical addresses. It holds one table of 64-bit translation control entries (TCEs) in an internal synchronous RAM. A lookup takes a window-relative bus address and splits it into a page index and a page offset. The page index is the address shifted right by the configured page shift. The block returns four values: the page-aligned I/O virtual address, the page-aligned translated address taken from the entry, the page-offset mask, and the 2-bit access permission held in the entry's low bits.

A small command port handles the table's life cycle. The enable command sets the geometry (page shift, window base and entry count) and zeroes the live entries. The disable command drops the geometry. The clear command zeroes the entries and keeps the geometry. A plain entry write port lets a neighbouring update engine fill entries. All of this is driven by a three-state controller:

- `ST_OFF`: no table. The only transition is to `ST_SWEEP`, taken on an accepted enable with a nonzero count.
- `ST_SWEEP`: writes zero to one entry per cycle, starting at index 0. The transition back to `ST_ON` is taken after the entry at count-1 is written.
- `ST_ON`: serves lookups and writes. A disable goes to `ST_OFF`. A clear goes to `ST_SWEEP`.

Top module: `tce_xlate`

## Requirements
- R1: On an in-window lookup, `rsp_perm` equals bits [1:0] of the addressed entry. The codes are 0 = no access, 1 = read only, 2 = write only and 3 = read/write.
- R2: The entry index is `req_addr >> page_shift`. A lookup is in-window only when this index is less than the entry count. An accepted request gives `rsp_valid` high for exactly the one cycle that follows it.
- R3: On an in-window lookup, `rsp_mask` is 2^shift-1, `rsp_iova` is `req_addr` with the mask bits cleared, and `rsp_xlat` is the entry with the mask bits cleared.
- R4: On an out-of-window lookup, `rsp_iova` and `rsp_xlat` are zero, `rsp_mask` is all ones and `rsp_perm` is 0.
- R5: An enable (`cmd_op`=1) while the table is on sets `cmd_warn` for one cycle. It changes neither the geometry nor the entries.
- R6: An enable whose count exceeds the table depth, issued while the table is off, sets `cmd_err` for one cycle. The table stays off.
- R7: An accepted enable stores shift, base and count. It then holds `tbl_busy` high for exactly `count` cycles while it zeroes entries 0..count-1, after which `tbl_enabled` is high.
- R8: A disable (`cmd_op`=2) while on sets count, shift and base to zero and clears `tbl_enabled`. Every later lookup then faults as in R4.
- R9: A clear (`cmd_op`=3) while on zeroes the live entries over `count` busy cycles and keeps the geometry. While the table is off, a clear does nothing.
- R10: `win_size` equals count << shift, and `win_base` equals the stored base.
- R11: An entry write (`wr_valid`) while on and not busy stores `wr_data` at `wr_index`. Later lookups of that page return it.
- R12: While `tbl_busy` is high, lookup requests give no response, and entry writes and commands are ignored.
- R13: After reset the table is off, `win_size` and `win_base` are zero, and `rsp_valid`, `cmd_warn`, `cmd_err` and `tbl_busy` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command strobe |
| cmd_op | input | 2 | 0 none, 1 enable, 2 disable, 3 clear |
| cmd_shift | input | SH_W | Page shift for enable |
| cmd_base | input | ADDR_W | Window base for enable |
| cmd_count | input | CNT_W | Entry count for enable |
| cmd_warn | output | 1 | Enable refused, table already on |
| cmd_err | output | 1 | Enable refused, count above depth |
| wr_valid | input | 1 | Entry write strobe |
| wr_index | input | IDX_W | Entry index to write |
| wr_data | input | ENT_W | Entry value |
| req_valid | input | 1 | Lookup request |
| req_addr | input | ADDR_W | Window-relative bus address |
| rsp_valid | output | 1 | Lookup response valid |
| rsp_iova | output | ADDR_W | Page-aligned I/O virtual address |
| rsp_xlat | output | ENT_W | Page-aligned translated address |
| rsp_mask | output | ENT_W | Page-offset mask, all ones on a fault |
| rsp_perm | output | 2 | Access permission |
| tbl_enabled | output | 1 | Table holds a live geometry |
| tbl_busy | output | 1 | Zeroing sweep in progress |
| win_base | output | ADDR_W | Stored window base |
| win_size | output | ENT_W | Window size in bytes |

## Verification
The assertions assume that a command, an entry write and a lookup never fall in the same cycle. They also assume that the page shift given to enable stays below the address width, so the page mask and window size are well formed. The stimulus issues one action per cycle, uses only shifts of 12 and 16, and polls `tbl_busy` until it drops before it goes on. The exception is a small set of deliberate requests issued during a sweep, which check that the block ignores them.

// File: rtl/tce_pkg.sv
package tce_pkg;

    typedef enum logic [1:0] {
        OP_NOP     = 2'd0,
        OP_ENABLE  = 2'd1,
        OP_DISABLE = 2'd2,
        OP_CLEAR   = 2'd3
    } tce_op_e;

    typedef enum logic [1:0] {
        ST_OFF   = 2'd0,
        ST_SWEEP = 2'd1,
        ST_ON    = 2'd2
    } tbl_state_e;

    typedef enum logic [1:0] {
        PERM_NONE = 2'd0,
        PERM_RD   = 2'd1,
        PERM_WR   = 2'd2,
        PERM_RW   = 2'd3
    } perm_e;

    localparam int DEF_PAGE_SHIFT = 12;

endpackage

// File: rtl/tce_ram.sv
module tce_ram #(
    parameter int ENT_W = 64,
    parameter int DEPTH = 64,
    parameter int IDX_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             we,
    input  logic [IDX_W-1:0] waddr,
    input  logic [ENT_W-1:0] wdata,
    input  logic             re,
    input  logic [IDX_W-1:0] raddr,
    output logic [ENT_W-1:0] rdata
);

    logic [ENT_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
        if (re) begin
            rdata <= mem[raddr];
        end
    end

endmodule

// File: rtl/tce_ctrl.sv
module tce_ctrl
    import tce_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int SH_W   = 6,
    parameter int DEPTH  = 64,
    parameter int IDX_W  = $clog2(DEPTH),
    parameter int CNT_W  = $clog2(DEPTH + 1),
    parameter int DEF_SH = DEF_PAGE_SHIFT
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  tce_op_e           cmd_op,
    input  logic [SH_W-1:0]   cmd_shift,
    input  logic [ADDR_W-1:0] cmd_base,
    input  logic [CNT_W-1:0]  cmd_count,
    output logic [CNT_W-1:0]  count_o,
    output logic [SH_W-1:0]   shift_o,
    output logic [ADDR_W-1:0] base_o,
    output logic              busy_o,
    output logic              enabled_o,
    output logic              clr_we_o,
    output logic [IDX_W-1:0]  clr_idx_o,
    output logic              warn_o,
    output logic              err_o
);

    localparam logic [CNT_W-1:0] DEPTH_C = CNT_W'(DEPTH);

    tbl_state_e        state_q, state_d;
    logic [CNT_W-1:0]  count_q;
    logic [SH_W-1:0]   shift_q;
    logic [ADDR_W-1:0] base_q;
    logic [IDX_W-1:0]  sweep_q;
    logic              warn_q, err_q;

    logic cmd_en, cmd_dis, cmd_clr, too_big, last_sweep;

    assign cmd_en     = cmd_valid && (cmd_op == OP_ENABLE);
    assign cmd_dis    = cmd_valid && (cmd_op == OP_DISABLE);
    assign cmd_clr    = cmd_valid && (cmd_op == OP_CLEAR);
    assign too_big    = cmd_count > DEPTH_C;
    assign last_sweep = (CNT_W'(sweep_q) == (count_q - CNT_W'(1)));

    // next-state decode
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_OFF: begin
                if (cmd_en && !too_big && (cmd_count != '0)) begin
                    state_d = ST_SWEEP;
                end
            end
            ST_SWEEP: begin
                if (last_sweep) begin
                    state_d = ST_ON;
                end
            end
            ST_ON: begin
                if (cmd_dis) begin
                    state_d = ST_OFF;
                end else if (cmd_clr) begin
                    state_d = ST_SWEEP;
                end
            end
            default: state_d = ST_OFF;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_OFF;
        end else begin
            state_q <= state_d;
        end
    end

    // geometry, sweep pointer and refusal flags
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count_q <= '0;
            shift_q <= SH_W'(DEF_SH);
            base_q  <= '0;
            sweep_q <= '0;
            warn_q  <= 1'b0;
            err_q   <= 1'b0;
        end else begin
            warn_q <= 1'b0;
            err_q  <= 1'b0;
            if (state_q == ST_SWEEP) begin
                sweep_q <= sweep_q + IDX_W'(1);
            end else begin
                sweep_q <= '0;
            end
            unique case (state_q)
                ST_OFF: begin
                    if (cmd_en) begin
                        if (too_big) begin
                            err_q <= 1'b1;
                        end else begin
                            count_q <= cmd_count;
                            shift_q <= cmd_shift;
                            base_q  <= cmd_base;
                        end
                    end
                end
                ST_ON: begin
                    if (cmd_en) begin
                        warn_q <= 1'b1;
                    end else if (cmd_dis) begin
                        count_q <= '0;
                        shift_q <= '0;
                        base_q  <= '0;
                    end
                end
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        busy_o    = (state_q == ST_SWEEP);
        enabled_o = (state_q != ST_OFF);
        clr_we_o  = (state_q == ST_SWEEP);
        clr_idx_o = sweep_q;
        count_o   = count_q;
        shift_o   = shift_q;
        base_o    = base_q;
        warn_o    = warn_q;
        err_o     = err_q;
    end

endmodule

// File: rtl/tce_lookup.sv
module tce_lookup
    import tce_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int ENT_W  = 64,
    parameter int SH_W   = 6,
    parameter int IDX_W  = 6,
    parameter int CNT_W  = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              busy,
    input  logic [SH_W-1:0]   shift,
    input  logic [CNT_W-1:0]  count,
    output logic              rd_en,
    output logic [IDX_W-1:0]  rd_idx,
    input  logic [ENT_W-1:0]  rd_data,
    output logic              rsp_valid,
    output logic [ADDR_W-1:0] rsp_iova,
    output logic [ENT_W-1:0]  rsp_xlat,
    output logic [ENT_W-1:0]  rsp_mask,
    output logic [1:0]        rsp_perm
);

    logic [ADDR_W-1:0] idx_full;
    logic              hit_now, accept;
    logic [ENT_W-1:0]  mask_now;

    logic              vld_q, hit_q;
    logic [ADDR_W-1:0] addr_q;
    logic [ENT_W-1:0]  mask_q;

    always_comb begin
        idx_full = req_addr >> shift;
        hit_now  = idx_full < ADDR_W'(count);
        accept   = req_valid && !busy;
        mask_now = (ENT_W'(1) << shift) - ENT_W'(1);
        rd_en    = accept;
        rd_idx   = idx_full[IDX_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_q  <= 1'b0;
            hit_q  <= 1'b0;
            addr_q <= '0;
            mask_q <= '1;
        end else begin
            vld_q <= accept;
            if (accept) begin
                hit_q  <= hit_now;
                addr_q <= req_addr;
                mask_q <= mask_now;
            end
        end
    end

    always_comb begin
        rsp_valid = vld_q;
        if (hit_q) begin
            rsp_iova = addr_q & ~mask_q[ADDR_W-1:0];
            rsp_xlat = rd_data & ~mask_q;
            rsp_mask = mask_q;
            rsp_perm = rd_data[1:0];
        end else begin
            rsp_iova = '0;
            rsp_xlat = '0;
            rsp_mask = '1;
            rsp_perm = PERM_NONE;
        end
    end

endmodule

// File: rtl/tce_xlate.sv
module tce_xlate
    import tce_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int ENT_W  = 64,
    parameter int SH_W   = 6,
    parameter int DEPTH  = 64,
    parameter int IDX_W  = $clog2(DEPTH),
    parameter int CNT_W  = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic [1:0]        cmd_op,
    input  logic [SH_W-1:0]   cmd_shift,
    input  logic [ADDR_W-1:0] cmd_base,
    input  logic [CNT_W-1:0]  cmd_count,
    output logic              cmd_warn,
    output logic              cmd_err,
    input  logic              wr_valid,
    input  logic [IDX_W-1:0]  wr_index,
    input  logic [ENT_W-1:0]  wr_data,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    output logic              rsp_valid,
    output logic [ADDR_W-1:0] rsp_iova,
    output logic [ENT_W-1:0]  rsp_xlat,
    output logic [ENT_W-1:0]  rsp_mask,
    output logic [1:0]        rsp_perm,
    output logic              tbl_enabled,
    output logic              tbl_busy,
    output logic [ADDR_W-1:0] win_base,
    output logic [ENT_W-1:0]  win_size
);

    logic [CNT_W-1:0] count;
    logic [SH_W-1:0]  shift;
    logic             clr_we, wr_ok, rd_en, ram_we;
    logic [IDX_W-1:0] clr_idx, rd_idx, ram_waddr;
    logic [ENT_W-1:0] rd_data, ram_wdata;

    tce_ctrl #(
        .ADDR_W(ADDR_W), .SH_W(SH_W), .DEPTH(DEPTH),
        .IDX_W(IDX_W), .CNT_W(CNT_W), .DEF_SH(DEF_PAGE_SHIFT)
    ) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_valid (cmd_valid),
        .cmd_op    (tce_op_e'(cmd_op)),
        .cmd_shift (cmd_shift),
        .cmd_base  (cmd_base),
        .cmd_count (cmd_count),
        .count_o   (count),
        .shift_o   (shift),
        .base_o    (win_base),
        .busy_o    (tbl_busy),
        .enabled_o (tbl_enabled),
        .clr_we_o  (clr_we),
        .clr_idx_o (clr_idx),
        .warn_o    (cmd_warn),
        .err_o     (cmd_err)
    );

    // entry writes only land inside a live, idle window
    assign wr_ok     = wr_valid && tbl_enabled && !tbl_busy
                       && (CNT_W'(wr_index) < count);
    assign ram_we    = clr_we || wr_ok;
    assign ram_waddr = clr_we ? clr_idx : wr_index;
    assign ram_wdata = clr_we ? '0 : wr_data;

    tce_ram #(.ENT_W(ENT_W), .DEPTH(DEPTH), .IDX_W(IDX_W)) u_ram (
        .clk   (clk),
        .we    (ram_we),
        .waddr (ram_waddr),
        .wdata (ram_wdata),
        .re    (rd_en),
        .raddr (rd_idx),
        .rdata (rd_data)
    );

    tce_lookup #(
        .ADDR_W(ADDR_W), .ENT_W(ENT_W), .SH_W(SH_W),
        .IDX_W(IDX_W), .CNT_W(CNT_W)
    ) u_lookup (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_addr  (req_addr),
        .busy      (tbl_busy),
        .shift     (shift),
        .count     (count),
        .rd_en     (rd_en),
        .rd_idx    (rd_idx),
        .rd_data   (rd_data),
        .rsp_valid (rsp_valid),
        .rsp_iova  (rsp_iova),
        .rsp_xlat  (rsp_xlat),
        .rsp_mask  (rsp_mask),
        .rsp_perm  (rsp_perm)
    );

    assign win_size = ENT_W'(count) << shift;

endmodule

// File: rtl/tce_xlate_chk.sv
module tce_xlate_chk #(
    parameter int ADDR_W = 32,
    parameter int ENT_W  = 64,
    parameter int SH_W   = 6,
    parameter int CNT_W  = 7
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cmd_valid,
    input logic [1:0]        cmd_op,
    input logic              cmd_warn,
    input logic              cmd_err,
    input logic              req_valid,
    input logic              rsp_valid,
    input logic [ADDR_W-1:0] rsp_iova,
    input logic [ENT_W-1:0]  rsp_xlat,
    input logic [ENT_W-1:0]  rsp_mask,
    input logic [1:0]        rsp_perm,
    input logic              tbl_enabled,
    input logic              tbl_busy,
    input logic [ADDR_W-1:0] win_base,
    input logic [ENT_W-1:0]  win_size
);

    p_rsp_latency_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !tbl_busy) |=> rsp_valid);

    p_no_rsp_busy_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_valid && !tbl_busy) |=> !rsp_valid);

    p_miss_shape_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && (rsp_mask == '1)) |->
            (rsp_iova == '0 && rsp_xlat == '0 && rsp_perm == 2'd0));

    p_page_align_r3: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> ((rsp_xlat & rsp_mask) == '0
                       && (ENT_W'(rsp_iova) & rsp_mask) == '0));

    p_warn_keeps_r5: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_warn |-> (tbl_enabled && win_size == $past(win_size)
                      && win_base == $past(win_base)));

    p_err_stays_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_err |-> (!tbl_enabled && !tbl_busy));

    p_disable_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_op == 2'd2 && tbl_enabled && !tbl_busy) |=>
            (!tbl_enabled && win_size == '0 && win_base == '0));

    p_off_faults_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !tbl_busy && !tbl_enabled) |=> (rsp_mask == '1));

    p_sweep_keeps_geom_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (tbl_busy && $past(tbl_busy)) |-> $stable(win_size));

endmodule

bind tce_xlate tce_xlate_chk #(
    .ADDR_W(ADDR_W), .ENT_W(ENT_W), .SH_W(SH_W), .CNT_W(CNT_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cmd_valid   (cmd_valid),
    .cmd_op      (cmd_op),
    .cmd_warn    (cmd_warn),
    .cmd_err     (cmd_err),
    .req_valid   (req_valid),
    .rsp_valid   (rsp_valid),
    .rsp_iova    (rsp_iova),
    .rsp_xlat    (rsp_xlat),
    .rsp_mask    (rsp_mask),
    .rsp_perm    (rsp_perm),
    .tbl_enabled (tbl_enabled),
    .tbl_busy    (tbl_busy),
    .win_base    (win_base),
    .win_size    (win_size)
);

// File: tb/sim_tce_xlate.sv
`timescale 1ns/1ps
module sim_tce_xlate;

    localparam int ADDR_W = 32;
    localparam int ENT_W  = 64;
    localparam int SH_W   = 6;
    localparam int DEPTH  = 64;
    localparam int IDX_W  = 6;
    localparam int CNT_W  = 7;

    // {expected in-window, address}, table geometry shift 12 count 16
    localparam logic [32:0] VEC [8] = '{
        {1'b1, 32'h0000_0123}, {1'b1, 32'h0000_5ABC},
        {1'b1, 32'h0000_FFFF}, {1'b1, 32'h0000_3004},
        {1'b1, 32'h0000_6000}, {1'b0, 32'h0001_0000},
        {1'b0, 32'hFFFF_FFFF}, {1'b1, 32'h0000_E7F1}
    };

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cmd_valid = 1'b0;
    logic [1:0]        cmd_op = 2'd0;
    logic [SH_W-1:0]   cmd_shift = '0;
    logic [ADDR_W-1:0] cmd_base = '0;
    logic [CNT_W-1:0]  cmd_count = '0;
    logic              cmd_warn, cmd_err;
    logic              wr_valid = 1'b0;
    logic [IDX_W-1:0]  wr_index = '0;
    logic [ENT_W-1:0]  wr_data = '0;
    logic              req_valid = 1'b0;
    logic [ADDR_W-1:0] req_addr = '0;
    logic              rsp_valid;
    logic [ADDR_W-1:0] rsp_iova;
    logic [ENT_W-1:0]  rsp_xlat, rsp_mask;
    logic [1:0]        rsp_perm;
    logic              tbl_enabled, tbl_busy;
    logic [ADDR_W-1:0] win_base;
    logic [ENT_W-1:0]  win_size;

    always #10 clk = ~clk;

    tce_xlate #(
        .ADDR_W(ADDR_W), .ENT_W(ENT_W), .SH_W(SH_W),
        .DEPTH(DEPTH), .IDX_W(IDX_W), .CNT_W(CNT_W)
    ) u0 (.*);

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;
    logic [ENT_W-1:0] shadow [DEPTH];
    int sh_m = 0;
    int cnt_m = 0;

    task automatic chk(input bit ok, input string req,
                       input logic [63:0] act, input logic [63:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [ENT_W-1:0] pat(input int i);
        return 64'h00C0_0000_0000_0000 + (64'(i) * 64'h1_1000)
               + 64'h0AB0 + 64'(i % 4);
    endfunction

    task automatic model_zero();
        for (int i = 0; i < DEPTH; i++) shadow[i] = '0;
    endtask

    task automatic send_cmd(input logic [1:0] op, input int sh,
                            input logic [31:0] base, input int cnt);
        cmd_valid = 1'b1; cmd_op = op; cmd_shift = SH_W'(sh);
        cmd_base = base; cmd_count = CNT_W'(cnt);
        @(negedge clk);
        cmd_valid = 1'b0; cmd_op = 2'd0;
    endtask

    task automatic wait_idle(output int cyc);
        cyc = 0;
        while (tbl_busy) begin
            cyc++;
            @(negedge clk);
        end
    endtask

    task automatic put(input int idx, input logic [ENT_W-1:0] d);
        wr_valid = 1'b1; wr_index = IDX_W'(idx); wr_data = d;
        @(negedge clk);
        wr_valid = 1'b0;
    endtask

    task automatic lookup(input logic [31:0] a, input string req);
        logic [31:0] e_iova;
        logic [63:0] e_x, e_m;
        logic [1:0]  e_p;
        logic [31:0] idx;
        idx = a >> sh_m;
        if (idx < 32'(cnt_m)) begin
            e_m = (64'd1 << sh_m) - 64'd1;
            e_iova = a & ~e_m[31:0];
            e_x = shadow[idx] & ~e_m;
            e_p = shadow[idx][1:0];
        end else begin
            e_m = '1; e_iova = '0; e_x = '0; e_p = 2'd0;
        end
        req_valid = 1'b1; req_addr = a;
        @(negedge clk);
        req_valid = 1'b0;
        chk(rsp_valid === 1'b1, {req, " R2 rsp_valid"}, 64'(rsp_valid), 64'd1);
        chk(rsp_iova === e_iova, {req, " iova"}, 64'(rsp_iova), 64'(e_iova));
        chk(rsp_xlat === e_x, {req, " xlat"}, rsp_xlat, e_x);
        chk(rsp_mask === e_m, {req, " mask"}, rsp_mask, e_m);
        chk(rsp_perm === e_p, {req, " perm R1"}, 64'(rsp_perm), 64'(e_p));
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        int cyc;
        model_zero();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R13 reset state
        chk(tbl_enabled === 1'b0, "R13 enabled", 64'(tbl_enabled), 0);
        chk(win_size === '0, "R13 win_size", win_size, 0);
        chk(win_base === '0, "R13 win_base", 64'(win_base), 0);
        chk(rsp_valid === 1'b0 && tbl_busy === 1'b0, "R13 valid/busy",
            64'({rsp_valid, tbl_busy}), 0);
        chk(cmd_warn === 1'b0 && cmd_err === 1'b0, "R13 flags",
            64'({cmd_warn, cmd_err}), 0);

        // R4 fault while off
        lookup(32'h0000_1000, "R4 off lookup");

        // R7 enable shift 12, count 16
        send_cmd(2'd1, 12, 32'h8000_0000, 16);
        sh_m = 12; cnt_m = 16; model_zero();
        wait_idle(cyc);
        chk(cyc == 16, "R7 sweep cycles", 64'(cyc), 16);
        chk(tbl_enabled === 1'b1, "R7 enabled", 64'(tbl_enabled), 1);
        chk(win_size === 64'h1_0000, "R10 win_size", win_size, 64'h1_0000);
        chk(win_base === 32'h8000_0000, "R10 win_base", 64'(win_base), 64'h8000_0000);
        lookup(32'h0000_3004, "R7 zeroed entry");

        // R11 fill entries
        for (int i = 0; i < 16; i++) begin
            put(i, pat(i));
            shadow[i] = pat(i);
        end

        // vector walk: R1 R2 R3 R4
        for (int k = 0; k < 8; k++) begin
            lookup(VEC[k][31:0], "R3 vector");
            chk((rsp_mask !== '1) == VEC[k][32], "R2 window decision",
                64'(rsp_mask !== '1), 64'(VEC[k][32]));
        end
        @(negedge clk);
        chk(rsp_valid === 1'b0, "R2 single-cycle response", 64'(rsp_valid), 0);

        // R5 enable while on
        send_cmd(2'd1, 16, 32'h0, 8);
        chk(cmd_warn === 1'b1 && cmd_err === 1'b0, "R5 warn pulse",
            64'({cmd_warn, cmd_err}), 64'd2);
        chk(win_size === 64'h1_0000 && tbl_busy === 1'b0, "R5 geometry kept",
            win_size, 64'h1_0000);
        lookup(32'h0000_5ABC, "R5 entry kept");

        // R9 clear with R12 ignored actions during sweep
        send_cmd(2'd3, 0, 32'h0, 0);
        model_zero();
        chk(tbl_busy === 1'b1, "R9 clear busy", 64'(tbl_busy), 1);
        @(negedge clk);
        @(negedge clk);
        put(0, 64'hDEAD_BEEF_0000_0003);
        req_valid = 1'b1; req_addr = 32'h0000_5000;
        @(negedge clk);
        req_valid = 1'b0;
        chk(rsp_valid === 1'b0, "R12 no response while busy", 64'(rsp_valid), 0);
        send_cmd(2'd2, 0, 32'h0, 0);
        wait_idle(cyc);
        chk(tbl_enabled === 1'b1, "R12 disable ignored", 64'(tbl_enabled), 1);
        chk(win_size === 64'h1_0000, "R9 geometry kept", win_size, 64'h1_0000);
        lookup(32'h0000_0040, "R12 write ignored");
        lookup(32'h0000_5ABC, "R9 entry zeroed");

        // R8 disable
        send_cmd(2'd2, 0, 32'h0, 0);
        sh_m = 0; cnt_m = 0;
        chk(tbl_enabled === 1'b0, "R8 disabled", 64'(tbl_enabled), 0);
        chk(win_size === '0 && win_base === '0, "R8 geometry zero",
            win_size | 64'(win_base), 0);
        lookup(32'h0000_0000, "R8 fault after disable");

        // R9 clear while off does nothing
        send_cmd(2'd3, 0, 32'h0, 0);
        chk(tbl_busy === 1'b0 && tbl_enabled === 1'b0, "R9 clear while off",
            64'({tbl_busy, tbl_enabled}), 0);

        // R6 count above depth
        send_cmd(2'd1, 12, 32'h0, DEPTH + 1);
        chk(cmd_err === 1'b1 && cmd_warn === 1'b0, "R6 err pulse",
            64'({cmd_warn, cmd_err}), 64'd1);
        chk(tbl_enabled === 1'b0 && tbl_busy === 1'b0, "R6 stays off",
            64'({tbl_enabled, tbl_busy}), 0);
        @(negedge clk);
        chk(cmd_err === 1'b0, "R6 err one cycle", 64'(cmd_err), 0);

        // R7 boundary: full depth with shift 16
        send_cmd(2'd1, 16, 32'h0004_0000, DEPTH);
        sh_m = 16; cnt_m = DEPTH; model_zero();
        wait_idle(cyc);
        chk(cyc == DEPTH, "R7 full-depth sweep", 64'(cyc), 64'(DEPTH));
        chk(win_size === 64'h40_0000, "R10 full window", win_size, 64'h40_0000);
        put(DEPTH - 1, pat(7));
        shadow[DEPTH - 1] = pat(7);
        lookup(32'((DEPTH - 1) << 16) | 32'hABCD, "R2 last page");
        lookup(32'(DEPTH << 16), "R4 first page past end");

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule